// File: doc/BRIEF.md
# System Control Port with NMI Mask

This block is the system control port of a PC/AT-style platform. It holds one I/O port whose low four bits are writable control and whose upper four bits read back status. The control bits run the speaker path and the gate of timer channel 2, and they enable the two NMI check sources. The upper bits report the two latched NMI sources and the live level of the timer channel-2 output.

A second I/O port is write-only and carries two unrelated fields. Bit 7 is an active-low master NMI mask, and bits 6 to 0 hold an index for the real-time clock. The master mask resets to the blocking state. While it blocks, no NMI leaves the block, whatever the per-source enables say.

The CPU drives the block over a plain I/O bus: address, write data, write strobe and read strobe. The read data is combinational. The timer and the real-time clock are outside the block.

Top module: `sys_ctl_port`

## Requirements
- R1: After reset, the control nibble is 0, the master mask is 1 (blocking), the clock index is 0, both source latches are clear, and `nmi`, `tmr2_gate` and `spkr` are 0.
- R2: A write to address 0x61 stores `io_wdata[3:0]` as the control nibble and ignores `io_wdata[7:4]`. A write to any address other than 0x61 or 0x70 changes no state.
- R3: A read at 0x61 returns {parity latch, channel latch, `tmr2_out`, 0, control nibble} in bits 7 to 0. A read at 0x70 or at any other address returns 0xFF.
- R4: A write to 0x70 stores `io_wdata[7]` as the master mask and `io_wdata[6:0]` as `rtc_index`, each independently of the other.
- R5: While the master mask is 1, `nmi` is 0 regardless of the latched sources and their enables.
- R6: With control bit 2 = 0, a high `parity_err` at a clock edge sets the parity latch. While bit 2 = 1 the latch reads 0 and is cleared at the next edge.
- R7: With control bit 3 = 0, a high `chan_chk` at a clock edge sets the channel latch. While bit 3 = 1 the latch reads 0 and is cleared at the next edge.
- R8: `nmi` is 1 exactly when the mask is 0 and at least one enabled source latch is set. It stays high until the source is disabled or masked.
- R9: `tmr2_gate` equals control bit 0.
- R10: `spkr` equals `tmr2_out` AND control bit 1.
- R11: A write that disables a source, arriving in the same cycle as that source's event, leaves `nmi` low and the readback bit 0. One edge later the latch is clear.
- R12: Clearing the mask while an enabled source is latched raises `nmi` right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data (combinational) |
| parity_err | input | 1 | Parity check NMI source |
| chan_chk | input | 1 | Channel check NMI source |
| tmr2_out | input | 1 | Timer channel-2 output |
| nmi | output | 1 | NMI request, active high |
| tmr2_gate | output | 1 | Timer channel-2 gate |
| spkr | output | 1 | Speaker output |
| rtc_index | output | 7 | Real-time clock index |

## Verification
A source event and a control write can land on the same clock edge. When they do, the latch captures the event under the old enable, while the output and readback already obey the new one. The bench provokes this by pulsing `parity_err` in the very cycle that it writes a disable to 0x61. It then judges that `nmi` stays low, that the readback bit is 0, and that a later write re-enabling the source finds the latch already clear. A mask write that lands while a source is latched is also driven, and the bench checks that `nmi` rises right after that edge.

// File: rtl/sys_ctl_port.sv
module sys_ctl_port #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORTB_ADDR = 'h61,
  parameter logic [ADDR_W-1:0] MASK_ADDR  = 'h70,
  parameter logic [7:0] FLOAT_DATA = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic              parity_err,
  input  logic              chan_chk,
  input  logic              tmr2_out,
  output logic              nmi,
  output logic              tmr2_gate,
  output logic              spkr,
  output logic [6:0]        rtc_index
);

  logic [3:0] ctl;
  logic       nmi_block;
  logic [6:0] idx;
  logic       par_lat, chk_lat;

  wire pb_sel  = io_addr == PORTB_ADDR;
  wire pb_wr   = io_wr && pb_sel;
  wire mk_wr   = io_wr && (io_addr == MASK_ADDR);
  wire par_on  = par_lat & ~ctl[2];
  wire chk_on  = chk_lat & ~ctl[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= '0;
      nmi_block <= 1'b1;
      idx       <= '0;
      par_lat   <= 1'b0;
      chk_lat   <= 1'b0;
    end else begin
      if (pb_wr) ctl <= io_wdata[3:0];
      if (mk_wr) {nmi_block, idx} <= io_wdata;
      par_lat <= ~ctl[2] & (par_lat | parity_err);
      chk_lat <= ~ctl[3] & (chk_lat | chan_chk);
    end
  end

  assign nmi       = ~nmi_block & (par_on | chk_on);
  assign tmr2_gate = ctl[0];
  assign spkr      = tmr2_out & ctl[1];
  assign rtc_index = idx;
  assign io_rdata  = (io_rd && pb_sel) ? {par_on, chk_on, tmr2_out, 1'b0, ctl}
                                       : FLOAT_DATA;

endmodule

module sys_ctl_port_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORTB_ADDR = 'h61,
  parameter logic [ADDR_W-1:0] MASK_ADDR  = 'h70,
  parameter logic [7:0] FLOAT_DATA = 8'hFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic              tmr2_out,
  input logic              nmi,
  input logic              tmr2_gate,
  input logic              spkr,
  input logic [6:0]        rtc_index
);

  // R5
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == MASK_ADDR && io_wdata[7]) |=> !nmi);

  // R4
  rtc_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == MASK_ADDR) |=> rtc_index == $past(io_wdata[6:0]));

  // R9
  gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORTB_ADDR) |=> tmr2_gate == $past(io_wdata[0]));

  // R10
  spkr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spkr |-> tmr2_out);

  // R11
  both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORTB_ADDR && io_wdata[2] && io_wdata[3]) |=> !nmi);

  // R3
  float_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr != PORTB_ADDR) |-> io_rdata == FLOAT_DATA);

endmodule

bind sys_ctl_port sys_ctl_port_chk #(
  .ADDR_W(ADDR_W), .PORTB_ADDR(PORTB_ADDR), .MASK_ADDR(MASK_ADDR),
  .FLOAT_DATA(FLOAT_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .tmr2_out(tmr2_out),
  .nmi(nmi), .tmr2_gate(tmr2_gate), .spkr(spkr), .rtc_index(rtc_index)
);

// File: tb/sys_ctl_port_tb.sv
module sys_ctl_port_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic parity_err = 1'b0, chan_chk = 1'b0, tmr2_out = 1'b0;
  logic nmi, tmr2_gate, spkr;
  logic [6:0] rtc_index;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sys_ctl_port dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .parity_err(parity_err), .chan_chk(chan_chk), .tmr2_out(tmr2_out),
    .nmi(nmi), .tmr2_gate(tmr2_gate), .spkr(spkr), .rtc_index(rtc_index)
  );

  // {addr[15:0], wdata[7:0], par, chan, out2, exp_nmi, exp_spkr, exp_gate, exp_rd[7:0]}
  localparam int NV = 12;
  localparam logic [37:0] VEC [NV] = '{
    {16'h0061, 8'h03, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h23},
    {16'h0061, 8'hF1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h21},
    {16'h0061, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02},
    {16'h0070, 8'h05, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h82},
    {16'h0070, 8'h85, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC2},
    {16'h0070, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC2},
    {16'h0061, 8'h06, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h66},
    {16'h0061, 8'h0E, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2E},
    {16'h0061, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {16'h0061, 8'h0C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0C},
    {16'h0061, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {16'h0062, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic read_pb;
    io_addr = 16'h0061; io_rd = 1'b1; #1;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    tmr2_out = 1'b1;
    read_pb();
    chk("R1 nmi", {7'd0, nmi}, 8'h00);
    chk("R1 gate", {7'd0, tmr2_gate}, 8'h00);
    chk("R1 spkr", {7'd0, spkr}, 8'h00);
    chk("R1 rtc_index", {1'b0, rtc_index}, 8'h00);
    chk("R1/R3 portb read", io_rdata, 8'h20);
    io_addr = 16'h0070; #1;
    chk("R3 read 0x70 floats", io_rdata, 8'hFF);
    io_rd = 1'b0; tmr2_out = 1'b0;
    // default mask blocks an enabled, latched source
    @(negedge clk); parity_err = 1'b1;
    @(negedge clk); parity_err = 1'b0;
    read_pb();
    chk("R5 default mask blocks nmi", {7'd0, nmi}, 8'h00);
    chk("R6 parity latched", io_rdata, 8'h80);
    io_rd = 1'b0;

    do_reset();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      io_addr = VEC[i][37:22]; io_wdata = VEC[i][21:14]; io_wr = 1'b1;
      parity_err = VEC[i][13]; chan_chk = VEC[i][12]; tmr2_out = VEC[i][11];
      @(negedge clk);
      io_wr = 1'b0; parity_err = 1'b0; chan_chk = 1'b0;
      read_pb();
      chk($sformatf("R8/R12 vec%0d nmi", i), {7'd0, nmi}, {7'd0, VEC[i][10]});
      chk($sformatf("R10 vec%0d spkr", i), {7'd0, spkr}, {7'd0, VEC[i][9]});
      chk($sformatf("R9 vec%0d gate", i), {7'd0, tmr2_gate}, {7'd0, VEC[i][8]});
      chk($sformatf("R2/R6/R7/R11 vec%0d readback", i), io_rdata, VEC[i][7:0]);
      io_rd = 1'b0;
    end

    write(16'h0070, 8'hFF);
    #1;
    chk("R4 rtc_index full", {1'b0, rtc_index}, 8'h7F);
    write(16'h0070, 8'h2A);
    #1;
    chk("R4 rtc_index with mask 0", {1'b0, rtc_index}, 8'h2A);
    // channel source with mask 0, then disable via bit 3
    @(negedge clk); chan_chk = 1'b1;
    @(negedge clk); chan_chk = 1'b0; #1;
    chk("R7 channel raises nmi", {7'd0, nmi}, 8'h01);
    write(16'h0061, 8'h08);
    write(16'h0061, 8'h00);
    read_pb();
    chk("R7 channel latch cleared", io_rdata, 8'h00);
    chk("R7 nmi low after clear", {7'd0, nmi}, 8'h00);
    io_rd = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule